// File: doc/BRIEF.md
# Analog Pin Boundary Control Cells

This block is the digital control for one analog pin of a boundary-scan chain. It holds a four-cell segment of the boundary register: calibrate, control, data1 and data2. The TAP controller shifts, captures and updates the segment through strobes. On each update strobe the block combines the updated cells with the active instruction. From these it produces the registered enables for six analog switches. Those switches tie the pin to the core, the high rail, the low rail, the reference ground, analog bus 1 (stimulus) and analog bus 2 (monitor).

The block also digitizes the pin. The comparator result is resynchronized and placed into the segment on a capture strobe, so the TAP can read it out serially. Across the test instructions, the decode covers twenty connection states. There are five base connections (isolated, high rail, low rail, reference ground, core), and each can be combined with or without bus 1 and bus 2.

Top module: `abm_ctrl`

## Requirements
- R1: After reset the switch outputs select the core only (`sw_core_o`=1, all others 0), `conflict_o`=0 and `tdo_o`=0.
- R2: With `sel_i`=1 and `shift_en_i`=1, each rising clock moves the segment one place: `tdi_i` enters the calibrate cell, calibrate moves to control, control to data1, data1 to data2, and `tdo_o` shows the data2 cell. So the first of four shifted bits lands in data2, then data1, control, calibrate.
- R3: With `sel_i`=1 and `capture_en_i`=1, the data2 position loads the digitized pin value (1 when `cmp_i` is high, after `SYNC_STAGES` clocks of resynchronization). The calibrate, control and data1 positions load their currently updated values.
- R4: Switch outputs and `conflict_o` change only on a clock edge where `update_en_i`=1. Shifting and capturing leave them unchanged.
- R5: Under INTEST (code 3), {data1,data2} selects the base connection: 00 high rail, 01 low rail, 10 reference ground, 11 core. Control enables bus 1 and calibrate enables bus 2.
- R6: Under EXTEST (code 2), the core switch is off and ground is off. Data1 alone enables the high rail and data2 alone enables the low rail, so 00 leaves the pin isolated. Control and calibrate enable bus 1 and bus 2.
- R7: High and low rail are never on together. Under EXTEST with data1=data2=1, only the low rail is on and `conflict_o`=1. In every other decoded case `conflict_o`=0.
- R8: Under PROBE (code 4), the core is on, the rails and ground are off, and control and calibrate enable bus 1 and bus 2.
- R9: Under HIGHZ (code 6), all six switches are off.
- R10: Under CLAMP (code 5), an update turns the core switch off and holds every other switch output and `conflict_o` at its previous value.
- R11: Under BYPASS (0), SAMPLE (1) and RUNBIST (7), an update selects the core only, whatever the cells hold.
- R12: With `sel_i`=0, shift, capture and update leave the segment's cells unchanged. An update still re-decodes the held cells with the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 3 | Active instruction code |
| sel_i | input | 1 | Boundary register selected |
| shift_en_i | input | 1 | Shift strobe |
| capture_en_i | input | 1 | Capture strobe |
| update_en_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial input |
| tdo_o | output | 1 | Serial output (data2 cell) |
| cmp_i | input | 1 | Comparator result, pin above threshold |
| sw_core_o | output | 1 | Core connection switch enable |
| sw_hi_o | output | 1 | High rail switch enable |
| sw_lo_o | output | 1 | Low rail switch enable |
| sw_gnd_o | output | 1 | Reference ground switch enable |
| sw_ab1_o | output | 1 | Bus 1 switch enable |
| sw_ab2_o | output | 1 | Bus 2 switch enable |
| conflict_o | output | 1 | Both rails requested, low rail kept |

## Verification
A corrupted update cell appears at the switch outputs on the first update strobe after the fault. A capture followed by four shifts then reads it back serially within five clocks. A fault in the shift path shows up as a mis-ordered bit on `tdo_o` during that readout. A decode fault shows up as a wrong enable one clock after the update strobe. A missed hold under CLAMP or a missed `sel_i` gate shows up as a switch that moves when it should stay put.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam int CELLS = 4;

  typedef enum logic [2:0] {
    INS_BYPASS  = 3'd0,
    INS_SAMPLE  = 3'd1,
    INS_EXTEST  = 3'd2,
    INS_INTEST  = 3'd3,
    INS_PROBE   = 3'd4,
    INS_CLAMP   = 3'd5,
    INS_HIGHZ   = 3'd6,
    INS_RUNBIST = 3'd7
  } abm_instr_e;

  typedef struct packed {
    logic core;
    logic hi;
    logic lo;
    logic gnd;
    logic ab1;
    logic ab2;
  } abm_sw_t;

  // bit 3 calibrate .. bit 0 data2
  typedef struct packed {
    logic cal;
    logic ctl;
    logic d1;
    logic d2;
  } abm_cells_t;

  localparam abm_sw_t SW_CORE_ONLY = '{core: 1'b1, default: 1'b0};
endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/abm_scan_seg.sv
module abm_scan_seg
  import abm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       shift_en_i,
  input  logic       capture_en_i,
  input  logic       update_en_i,
  input  logic       tdi_i,
  input  logic       dig_i,
  output logic       tdo_o,
  output abm_cells_t shift_o,
  output abm_cells_t upd_o
);
  logic [CELLS-1:0] sh_q;
  logic [CELLS-1:0] up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (sel_i && capture_en_i) begin
      sh_q <= {up_q[CELLS-1:1], dig_i};
    end else if (sel_i && shift_en_i) begin
      sh_q <= {tdi_i, sh_q[CELLS-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  up_q <= '0;
    else if (sel_i && update_en_i) up_q <= sh_q;
  end

  assign tdo_o   = sh_q[0];
  assign shift_o = abm_cells_t'(sh_q);
  assign upd_o   = abm_cells_t'(up_q);
endmodule

// File: rtl/abm_decode.sv
module abm_decode
  import abm_pkg::*;
(
  input  abm_cells_t  cells_i,
  input  logic [2:0]  instr_i,
  output abm_sw_t     sw_o,
  output logic        conflict_o
);
  abm_instr_e ins;
  assign ins = abm_instr_e'(instr_i);

  always_comb begin
    sw_o       = SW_CORE_ONLY;
    conflict_o = 1'b0;
    unique case (ins)
      INS_INTEST: begin
        sw_o      = '0;
        sw_o.ab1  = cells_i.ctl;
        sw_o.ab2  = cells_i.cal;
        unique case ({cells_i.d1, cells_i.d2})
          2'b00:   sw_o.hi   = 1'b1;
          2'b01:   sw_o.lo   = 1'b1;
          2'b10:   sw_o.gnd  = 1'b1;
          default: sw_o.core = 1'b1;
        endcase
      end
      INS_EXTEST: begin
        sw_o       = '0;
        sw_o.ab1   = cells_i.ctl;
        sw_o.ab2   = cells_i.cal;
        sw_o.lo    = cells_i.d2;
        // low rail wins a double request
        sw_o.hi    = cells_i.d1 & ~cells_i.d2;
        conflict_o = cells_i.d1 & cells_i.d2;
      end
      INS_PROBE: begin
        sw_o      = SW_CORE_ONLY;
        sw_o.ab1  = cells_i.ctl;
        sw_o.ab2  = cells_i.cal;
      end
      INS_HIGHZ: sw_o = '0;
      default:   sw_o = SW_CORE_ONLY;
    endcase
  end
endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl
  import abm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] instr_i,
  input  logic       sel_i,
  input  logic       shift_en_i,
  input  logic       capture_en_i,
  input  logic       update_en_i,
  input  logic       tdi_i,
  output logic       tdo_o,
  input  logic       cmp_i,
  output logic       sw_core_o,
  output logic       sw_hi_o,
  output logic       sw_lo_o,
  output logic       sw_gnd_o,
  output logic       sw_ab1_o,
  output logic       sw_ab2_o,
  output logic       conflict_o
);
  logic       dig;
  abm_cells_t sh_cells, up_cells, dec_cells;
  abm_sw_t    sw_next, sw_q;
  logic       conf_next, conf_q;

  abm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (dig)
  );

  abm_scan_seg u_seg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_i),
    .shift_en_i  (shift_en_i),
    .capture_en_i(capture_en_i),
    .update_en_i (update_en_i),
    .tdi_i       (tdi_i),
    .dig_i       (dig),
    .tdo_o       (tdo_o),
    .shift_o     (sh_cells),
    .upd_o       (up_cells)
  );

  // decode the value the cells hold after this update
  assign dec_cells = sel_i ? sh_cells : up_cells;

  abm_decode u_dec (
    .cells_i   (dec_cells),
    .instr_i   (instr_i),
    .sw_o      (sw_next),
    .conflict_o(conf_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= SW_CORE_ONLY;
      conf_q <= 1'b0;
    end else if (update_en_i) begin
      if (abm_instr_e'(instr_i) == INS_CLAMP) begin
        sw_q.core <= 1'b0;
      end else begin
        sw_q   <= sw_next;
        conf_q <= conf_next;
      end
    end
  end

  assign sw_core_o  = sw_q.core;
  assign sw_hi_o    = sw_q.hi;
  assign sw_lo_o    = sw_q.lo;
  assign sw_gnd_o   = sw_q.gnd;
  assign sw_ab1_o   = sw_q.ab1;
  assign sw_ab2_o   = sw_q.ab2;
  assign conflict_o = conf_q;
endmodule

// File: rtl/abm_ctrl_chk.sv
module abm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] instr_i,
  input logic       update_en_i,
  input logic       sw_core_o,
  input logic       sw_hi_o,
  input logic       sw_lo_o,
  input logic       sw_gnd_o,
  input logic       sw_ab1_o,
  input logic       sw_ab2_o,
  input logic       conflict_o
);
  logic [6:0] outs;
  assign outs = {sw_core_o, sw_hi_o, sw_lo_o, sw_gnd_o, sw_ab1_o, sw_ab2_o, conflict_o};

  assert_rails_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_hi_o && sw_lo_o));

  assert_conflict_keeps_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (sw_lo_o && !sw_hi_o));

  assert_hold_without_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_en_i |=> $stable(outs));

  assert_highz_all_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_en_i && instr_i == 3'd6) |=> (outs[6:1] == 6'b0));

  assert_clamp_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_en_i && instr_i == 3'd5) |=> (!sw_core_o && $stable(outs[5:0])));

  assert_probe_core_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_en_i && instr_i == 3'd4) |=> (sw_core_o && !sw_hi_o && !sw_lo_o && !sw_gnd_o));

  assert_extest_core_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_en_i && instr_i == 3'd2) |=> (!sw_core_o && !sw_gnd_o));
endmodule

bind abm_ctrl abm_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .update_en_i(update_en_i),
  .sw_core_o  (sw_core_o),
  .sw_hi_o    (sw_hi_o),
  .sw_lo_o    (sw_lo_o),
  .sw_gnd_o   (sw_gnd_o),
  .sw_ab1_o   (sw_ab1_o),
  .sw_ab2_o   (sw_ab2_o),
  .conflict_o (conflict_o)
);

// File: tb/abm_ctrl_bench.sv
module abm_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] instr = 3'd0;
  logic       sel = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic       tdi = 1'b0, cmp = 1'b0;
  logic       tdo;
  logic       core, hi, lo, gnd, ab1, ab2, conflict;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  abm_ctrl u_abm_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .sel_i(sel),
    .shift_en_i(shift_en), .capture_en_i(capture_en), .update_en_i(update_en),
    .tdi_i(tdi), .tdo_o(tdo), .cmp_i(cmp),
    .sw_core_o(core), .sw_hi_o(hi), .sw_lo_o(lo), .sw_gnd_o(gnd),
    .sw_ab1_o(ab1), .sw_ab2_o(ab2), .conflict_o(conflict)
  );

  // {conflict, core, hi, lo, gnd, ab1, ab2}
  function automatic logic [6:0] outs();
    return {conflict, core, hi, lo, gnd, ab1, ab2};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // v = {cal, ctl, d1, d2}; d2 shifted first
  task automatic shift_cells(input logic [3:0] v, input logic s);
    sel = s;
    for (int i = 0; i < 4; i++) begin
      tdi = v[i]; shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0; tdi = 1'b0;
  endtask

  task automatic update(input logic [2:0] ins, input logic s);
    instr = ins; sel = s; update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
  endtask

  task automatic load(input logic [3:0] v, input logic [2:0] ins);
    shift_cells(v, 1'b1);
    update(ins, 1'b1);
  endtask

  // capture then read four bits; result {cal, ctl, d1, dig}
  task automatic readback(output logic [3:0] r);
    sel = 1'b1; capture_en = 1'b1;
    @(negedge clk);
    capture_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      r[i] = tdo;
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset switches", outs(), 7'b0100000);
    check("R1 reset tdo", {6'b0, tdo}, 7'b0);
  endtask

  task automatic t_update_only();
    shift_cells(4'b0100, 1'b1);
    instr = 3'd3;
    check("R4 no change while shifting", outs(), 7'b0100000);
    update(3'd3, 1'b1);
    check("R4 change on update", outs(), 7'b0010010);
  endtask

  task automatic t_intest();
    load(4'b1000, 3'd3); check("R5 intest 00 high rail", outs(), 7'b0010001);
    load(4'b1001, 3'd3); check("R5 intest 01 low rail",  outs(), 7'b0001001);
    load(4'b1010, 3'd3); check("R5 intest 10 ground",    outs(), 7'b0000101);
    load(4'b1011, 3'd3); check("R5 intest 11 core",      outs(), 7'b0100001);
    load(4'b0111, 3'd3); check("R5 intest core bus1",    outs(), 7'b0100010);
  endtask

  task automatic t_extest();
    load(4'b1110, 3'd2); check("R6 extest high rail", outs(), 7'b0010011);
    load(4'b1101, 3'd2); check("R6 extest low rail",  outs(), 7'b0001011);
    load(4'b0000, 3'd2); check("R6 extest isolated",  outs(), 7'b0000000);
    load(4'b0111, 3'd2); check("R7 extest conflict low wins", outs(), 7'b1001010);
    load(4'b0010, 3'd3); check("R7 conflict cleared", outs(), 7'b0000100);
  endtask

  task automatic t_probe();
    load(4'b0100, 3'd4); check("R8 probe bus1", outs(), 7'b0100010);
    load(4'b1001, 3'd4); check("R8 probe bus2", outs(), 7'b0100001);
  endtask

  task automatic t_highz();
    load(4'b1111, 3'd6); check("R9 highz open", outs(), 7'b0000000);
  endtask

  task automatic t_clamp();
    load(4'b1011, 3'd3); check("R10 pre-clamp state", outs(), 7'b0100001);
    load(4'b0100, 3'd5); check("R10 clamp core off, hold", outs(), 7'b0000001);
    load(4'b0111, 3'd2);
    load(4'b0000, 3'd5); check("R10 clamp holds conflict", outs(), 7'b1001010);
  endtask

  task automatic t_mission();
    load(4'b1100, 3'd0); check("R11 bypass core only",  outs(), 7'b0100000);
    load(4'b1101, 3'd1); check("R11 sample core only",  outs(), 7'b0100000);
    load(4'b1110, 3'd7); check("R11 runbist core only", outs(), 7'b0100000);
  endtask

  task automatic t_capture();
    logic [3:0] r;
    load(4'b1010, 3'd3);
    cmp = 1'b1;
    repeat (4) @(negedge clk);
    readback(r);
    check("R3 capture digitized high", {3'b0, r}, {3'b0, 4'b1011});
    cmp = 1'b0;
    repeat (4) @(negedge clk);
    readback(r);
    check("R3 capture digitized low", {3'b0, r}, {3'b0, 4'b1010});
    shift_cells(4'b0001, 1'b1);
    check("R2 data2 at tdo after four shifts", {6'b0, tdo}, 7'd1);
    shift_en = 1'b1; sel = 1'b1; @(negedge clk); shift_en = 1'b0;
    check("R2 data1 follows", {6'b0, tdo}, 7'd0);
  endtask

  task automatic t_deselect();
    logic [3:0] r;
    load(4'b0001, 3'd3);
    check("R12 base", outs(), 7'b0001000);
    shift_cells(4'b1110, 1'b0);
    update(3'd3, 1'b0);
    check("R12 deselected update keeps cells", outs(), 7'b0001000);
    update(3'd2, 1'b0);
    check("R12 deselected update re-decodes", outs(), 7'b0001000);
    cmp = 1'b1;
    repeat (4) @(negedge clk);
    sel = 1'b0; capture_en = 1'b1; @(negedge clk); capture_en = 1'b0;
    readback(r);
    check("R12 cells readback", {3'b0, r}, {3'b0, 4'b0001});
    cmp = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_update_only();
    t_intest();
    t_extest();
    t_probe();
    t_highz();
    t_clamp();
    t_mission();
    t_capture();
    t_deselect();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule